// File: doc/BRIEF.md
# Linked-descriptor DMA channel engine

A single DMA channel sequencer that moves data beat by beat from a source address to a destination address. The work to be done is not held in length and address registers; it is read from memory as a chain of descriptors. Each descriptor gives a beat count, a source address, a destination address, a control word and a link to the next descriptor. The engine fetches a descriptor, runs its block, applies the block-end action the control word selects, and then follows the link until it meets a link of zero.

The channel is paced by a trigger input whose granularity is chosen per run: one trigger may release a single beat, a whole block, or the whole linked chain. At most one trigger is held pending. Sticky flags report block completion, suspension and errors. An abort stops the channel at once and leaves the remaining beat count of the current block readable.

Descriptor fetches and beats share one request/acknowledge bus port. Each access is a single word request held until acknowledged.

Top module: `dmx_channel`

## Requirements
- R1: A descriptor occupies four words at the pointer P: word P holds the beat count in bits 15:0 and the control word in bits 31:16; P+4 holds the source address; P+8 the destination address; P+12 the link. Control bits: 0 valid, 2:1 beat size (0 byte, 1 halfword, 2 word), 3 source increment, 4 destination increment, 6:5 block-end action. A bus request keeps its address and direction until acknowledged.
- R2: A link of zero ends the run after the current block and busy falls; a nonzero link is fetched and its block is run next.
- R3: With increment enabled, the stored address is the address just past the block, so the first beat uses stored minus count times beat bytes and each later beat adds the beat bytes; with increment off, every beat uses the stored address.
- R4: Each beat reads the source and then writes the read word to the destination; a block performs exactly its beat count of writes.
- R5: A first descriptor with a beat count of zero is rejected: status becomes 2 (invalid), busy falls, nothing is written and no error flag is set. A linked descriptor with a zero count is treated as an error.
- R6: Trigger mode 0 releases one beat per trigger, mode 1 one block per trigger, mode 2 the whole chain on one trigger.
- R7: Block-end action 0 does nothing, 1 sets the done flag, 2 suspends, 3 sets the done flag and suspends. A suspended channel stays busy and continues with the link on a resume pulse.
- R8: A bus error on any access, or a fetched descriptor whose valid bit is clear, sets the error flag and stops the channel (busy low).
- R9: A trigger that arrives while one is already pending is dropped.
- R10: Busy is high from an accepted start until completion, error or abort; an accepted start sets status 0 and clears the flags; a start while busy is ignored and sets status 1. After reset busy, flags, status and remaining count are zero.
- R11: Abort while busy returns the channel to idle on the next edge and leaves the remaining beat count of the current block on the remaining-count output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse |
| start_ptr | input | AW | Address of the first descriptor |
| trig | input | 1 | Transfer trigger pulse |
| trig_mode | input | 2 | Trigger granularity: 0 beat, 1 block, 2 chain |
| resume | input | 1 | Leaves the suspended state |
| abort | input | 1 | Stops the channel immediately |
| busy | output | 1 | Channel active |
| stat | output | 2 | Start status: 0 accepted, 1 busy, 2 invalid |
| remain | output | CW | Beats left in the current block |
| flag_done | output | 1 | Sticky block-complete flag |
| flag_susp | output | 1 | Sticky suspend flag |
| flag_err | output | 1 | Sticky error flag |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | Bus write (1) or read (0) |
| bus_addr | output | AW | Bus byte address |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | AW | Write data |
| bus_ack | input | 1 | Access acknowledge |
| bus_rdata | input | AW | Read data, valid with acknowledge |
| bus_err | input | 1 | Access error, valid with acknowledge |

## Verification
A wrong state in the sequencer shows at the bus port within one access: a misparsed descriptor word sends the first beat to a wrong address, and a wrong start-address derivation misplaces every write of the block, so the bench compares each write address and the copied memory. A lost or duplicated trigger grant shows as a wrong number of writes after a fixed wait, and a wrong block-end decode shows in the flags and busy as soon as the block's last write is acknowledged. Abort and error paths show on busy and the remaining count on the following edge.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_PARSE, S_WAIT, S_RD, S_WR, S_BEND, S_SUSP
  } dmx_state_e;

  typedef struct packed {
    logic [1:0] act;
    logic       dinc;
    logic       sinc;
    logic [1:0] size;
    logic       valid;
  } dmx_ctl_t;

  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_BUSY  = 2'd1;
  localparam logic [1:0] ST_INVAL = 2'd2;

  localparam logic [1:0] MODE_BEAT  = 2'd0;
  localparam logic [1:0] MODE_BLOCK = 2'd1;

  localparam logic [1:0] SIZE_WORD = 2'd2;
endpackage

// File: rtl/dmx_trig_gate.sv
module dmx_trig_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic trig,
  input  logic take,
  output logic pending
);
  logic pend_d;

  always_comb begin
    pend_d = pending;
    if (clr)       pend_d = 1'b0;
    else if (take) pend_d = 1'b0;
    else if (trig) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= pend_d;
  end
endmodule

// File: rtl/dmx_addr_unit.sv
module dmx_addr_unit #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] stored,
  input  logic [CW-1:0] count,
  input  logic [1:0]    size,
  input  logic          inc,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_d;
  logic          inc_q, inc_d;
  logic [AW-1:0] span, beat_bytes;

  always_comb begin
    beat_bytes = AW'(1) << size;
    span       = AW'(count) << size;
    addr_d     = addr;
    inc_d      = inc_q;
    if (load) begin
      inc_d  = inc;
      addr_d = inc ? (stored - span) : stored;
    end else if (step && inc_q) begin
      addr_d = addr + beat_bytes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      inc_q <= 1'b0;
    end else begin
      addr  <= addr_d;
      inc_q <= inc_d;
    end
  end
endmodule

// File: rtl/dmx_channel.sv
module dmx_channel
  import dmx_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_ptr,
  input  logic          trig,
  input  logic [1:0]    trig_mode,
  input  logic          resume,
  input  logic          abort,
  output logic          busy,
  output logic [1:0]    stat,
  output logic [CW-1:0] remain,
  output logic          flag_done,
  output logic          flag_susp,
  output logic          flag_err,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [AW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [AW-1:0] bus_rdata,
  input  logic          bus_err
);
  localparam int CTLW = $bits(dmx_ctl_t);

  dmx_state_e    state, state_d;
  logic [1:0]    idx, idx_d;
  logic [AW-1:0] ptr, ptr_d, src_st, src_st_d, dst_st, dst_st_d, link, link_d;
  logic [AW-1:0] data, data_d;
  logic [CW-1:0] cnt, cnt_d, remain_d;
  dmx_ctl_t      ctl, ctl_d;
  logic          grant, grant_d, first, first_d;
  logic [1:0]    stat_d;
  logic          done_d, susp_d, err_d;
  logic          take, clr_pend, ld, step, pending;
  logic [AW-1:0] src_addr, dst_addr;

  dmx_trig_gate u_gate (
    .clk(clk), .rst_n(rst_n), .clr(clr_pend), .trig(trig), .take(take), .pending(pending)
  );

  dmx_addr_unit #(.AW(AW), .CW(CW)) u_src (
    .clk(clk), .rst_n(rst_n), .load(ld), .step(step), .stored(src_st),
    .count(cnt), .size(ctl.size), .inc(ctl.sinc), .addr(src_addr)
  );

  dmx_addr_unit #(.AW(AW), .CW(CW)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(ld), .step(step), .stored(dst_st),
    .count(cnt), .size(ctl.size), .inc(ctl.dinc), .addr(dst_addr)
  );

  // next-state logic
  always_comb begin
    state_d = state;  idx_d = idx;  ptr_d = ptr;  src_st_d = src_st;
    dst_st_d = dst_st;  link_d = link;  data_d = data;  cnt_d = cnt;
    ctl_d = ctl;  remain_d = remain;  grant_d = grant;  first_d = first;
    stat_d = stat;  done_d = flag_done;  susp_d = flag_susp;  err_d = flag_err;
    take = 1'b0;  clr_pend = 1'b0;  ld = 1'b0;  step = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        ptr_d = start_ptr;  idx_d = '0;  first_d = 1'b1;  grant_d = 1'b0;
        stat_d = ST_OK;  done_d = 1'b0;  susp_d = 1'b0;  err_d = 1'b0;
        clr_pend = 1'b1;  state_d = S_FETCH;
      end
      S_FETCH: if (bus_ack) begin
        if (bus_err) begin
          err_d = 1'b1;  state_d = S_IDLE;
        end else begin
          case (idx)
            2'd0: begin cnt_d = bus_rdata[CW-1:0]; ctl_d = dmx_ctl_t'(bus_rdata[CW +: CTLW]); end
            2'd1: src_st_d = bus_rdata;
            2'd2: dst_st_d = bus_rdata;
            default: link_d = bus_rdata;
          endcase
          idx_d = idx + 2'd1;
          if (idx == 2'd3) state_d = S_PARSE;
        end
      end
      S_PARSE: begin
        if (!ctl.valid) begin
          err_d = 1'b1;  state_d = S_IDLE;
        end else if (cnt == '0) begin
          if (first) stat_d = ST_INVAL;
          else       err_d  = 1'b1;
          state_d = S_IDLE;
        end else begin
          ld = 1'b1;  remain_d = cnt;  first_d = 1'b0;  state_d = S_WAIT;
        end
      end
      S_WAIT: begin
        if (grant) begin
          state_d = S_RD;
        end else if (pending) begin
          take = 1'b1;  grant_d = 1'b1;  state_d = S_RD;
        end
      end
      S_RD: if (bus_ack) begin
        if (bus_err) begin err_d = 1'b1; state_d = S_IDLE; end
        else begin data_d = bus_rdata; state_d = S_WR; end
      end
      S_WR: if (bus_ack) begin
        if (bus_err) begin
          err_d = 1'b1;  state_d = S_IDLE;
        end else begin
          step = 1'b1;  remain_d = remain - CW'(1);
          if (trig_mode == MODE_BEAT) grant_d = 1'b0;
          state_d = (remain == CW'(1)) ? S_BEND : S_WAIT;
        end
      end
      S_BEND: begin
        if (ctl.act[0]) done_d = 1'b1;
        if (trig_mode == MODE_BLOCK) grant_d = 1'b0;
        if (ctl.act[1]) begin
          susp_d = 1'b1;  state_d = S_SUSP;
        end else if (link == '0) begin
          state_d = S_IDLE;
        end else begin
          ptr_d = link;  idx_d = '0;  state_d = S_FETCH;
        end
      end
      S_SUSP: if (resume) begin
        if (link == '0) state_d = S_IDLE;
        else begin ptr_d = link; idx_d = '0; state_d = S_FETCH; end
      end
      default: state_d = S_IDLE;
    endcase
    if (state != S_IDLE) begin
      if (start) stat_d = ST_BUSY;
      if (abort) begin
        state_d = S_IDLE;  remain_d = remain;  grant_d = 1'b0;
        done_d = flag_done;  susp_d = flag_susp;  err_d = flag_err;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  idx <= '0;  ptr <= '0;  src_st <= '0;  dst_st <= '0;
      link <= '0;  data <= '0;  cnt <= '0;  ctl <= '0;  remain <= '0;
      grant <= 1'b0;  first <= 1'b0;  stat <= ST_OK;
      flag_done <= 1'b0;  flag_susp <= 1'b0;  flag_err <= 1'b0;
    end else begin
      state <= state_d;  idx <= idx_d;  ptr <= ptr_d;  src_st <= src_st_d;
      dst_st <= dst_st_d;  link <= link_d;  data <= data_d;  cnt <= cnt_d;
      ctl <= ctl_d;  remain <= remain_d;  grant <= grant_d;  first <= first_d;
      stat <= stat_d;  flag_done <= done_d;  flag_susp <= susp_d;  flag_err <= err_d;
    end
  end

  // bus drive
  always_comb begin
    busy      = (state != S_IDLE);
    bus_req   = (state == S_FETCH) || (state == S_RD) || (state == S_WR);
    bus_we    = (state == S_WR);
    bus_wdata = data;
    bus_size  = (state == S_FETCH) ? SIZE_WORD : ctl.size;
    case (state)
      S_FETCH: bus_addr = ptr + AW'({idx, 2'b00});
      S_RD:    bus_addr = src_addr;
      default: bus_addr = dst_addr;
    endcase
  end
endmodule

// File: rtl/dmx_channel_chk.sv
module dmx_channel_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          abort,
  input logic          busy,
  input logic          flag_err,
  input logic          flag_susp,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ack
);
  a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    busy && abort |=> !busy);

  a_r8_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_err) |-> !busy);

  a_r7_susp_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_susp) |-> busy);

  a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && !abort |=> bus_req && $stable(bus_addr) && $stable(bus_we));

  a_r1_we_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> bus_req);
endmodule

bind dmx_channel dmx_channel_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .busy(busy),
  .flag_err(flag_err), .flag_susp(flag_susp), .bus_req(bus_req),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_ack(bus_ack)
);

// File: tb/sim_dmx_channel.sv
module sim_dmx_channel;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic start, trig, resume, abort;
  logic [AW-1:0] start_ptr;
  logic [1:0] trig_mode;
  logic busy, flag_done, flag_susp, flag_err;
  logic [1:0] stat;
  logic [CW-1:0] remain;
  logic bus_req, bus_we, bus_ack, bus_err;
  logic [AW-1:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0] bus_size;

  logic [31:0] mem [0:255];
  logic [31:0] log_addr [0:63];
  int log_cnt;
  logic [31:0] err_addr;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dmx_channel #(.AW(AW), .CW(CW)) u0 (.*);

  // memory model: acknowledges one cycle after a request
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0; bus_err <= 1'b0; bus_rdata <= '0;
    end else begin
      bus_ack <= 1'b0; bus_err <= 1'b0;
      if (bus_req && !bus_ack) begin
        bus_ack   <= 1'b1;
        bus_err   <= (bus_addr == err_addr);
        bus_rdata <= mem[bus_addr[9:2]];
        if (bus_we && bus_addr != err_addr) begin
          mem[bus_addr[9:2]] <= bus_wdata;
          if (log_cnt < 64) log_addr[log_cnt] <= bus_addr;
          log_cnt <= log_cnt + 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ctl_word(input bit valid, input int sz, input bit si,
                                           input bit di, input int act);
    return 16'(valid) | 16'(sz << 1) | 16'(si << 3) | 16'(di << 4) | 16'(act << 5);
  endfunction

  task automatic put_desc(input int base, input logic [15:0] ctl, input logic [15:0] cnt,
                          input logic [31:0] src, input logic [31:0] dst, input logic [31:0] nxt);
    mem[base/4]     = {ctl, cnt};
    mem[base/4 + 1] = src;
    mem[base/4 + 2] = dst;
    mem[base/4 + 3] = nxt;
  endtask

  task automatic prep();
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + 32'(i);
    log_cnt  = 0;
    err_addr = 32'hFFFF_FFFF;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start(input logic [31:0] p);
    start_ptr = p; start = 1'b1; cyc(1); start = 1'b0;
  endtask

  task automatic pulse_trig();
    trig = 1'b1; cyc(1); trig = 1'b0;
  endtask

  task automatic wait_idle(input int lim);
    int n = 0;
    while (busy && n < lim) begin cyc(1); n++; end
  endtask

  task automatic t_reset();
    chk("R10 reset busy", 32'(busy), 0);
    chk("R10 reset flags", {29'd0, flag_done, flag_susp, flag_err}, 0);
    chk("R10 reset stat", 32'(stat), 0);
    chk("R10 reset remain", 32'(remain), 0);
    chk("R1 reset no request", 32'(bus_req), 0);
  endtask

  // two linked word blocks, chain mode, incrementing addresses
  task automatic t_chain();
    prep();
    put_desc('h000, ctl_word(1, 2, 1, 1, 1), 16'd3, 32'h10C, 32'h20C, 32'h010);
    put_desc('h010, ctl_word(1, 2, 1, 1, 0), 16'd2, 32'h120, 32'h220, 32'h000);
    trig_mode = 2'd2;
    pulse_start(32'h000);
    pulse_trig();
    wait_idle(300);
    chk("R2 chain ends idle", 32'(busy), 0);
    chk("R4 chain write count", 32'(log_cnt), 5);
    chk("R3 first dest address", log_addr[0], 32'h200);
    chk("R3 second block dest", log_addr[3], 32'h218);
    chk("R4 copy word 0", mem['h200/4], 32'hA500_0040);
    chk("R4 copy word 2", mem['h208/4], 32'hA500_0042);
    chk("R2 linked block copy", mem['h21C/4], 32'hA500_0047);
    chk("R7 done flag action 1", 32'(flag_done), 1);
    chk("R10 accepted status", 32'(stat), 0);
  endtask

  // byte beats, fixed source, incrementing destination
  task automatic t_bytes();
    prep();
    put_desc('h000, ctl_word(1, 0, 0, 1, 0), 16'd4, 32'h140, 32'h284, 32'h000);
    trig_mode = 2'd2;
    pulse_start(32'h000);
    pulse_trig();
    wait_idle(300);
    chk("R4 byte beat count", 32'(log_cnt), 4);
    for (int i = 0; i < 4; i++) chk("R3 byte dest address", log_addr[i], 32'h280 + 32'(i));
    chk("R3 fixed source data", mem['h280/4], 32'hA500_0050);
    chk("R7 no action leaves done clear", 32'(flag_done), 0);
  endtask

  // beat granularity, duplicate trigger, abort
  task automatic t_beat();
    prep();
    put_desc('h000, ctl_word(1, 2, 1, 1, 0), 16'd3, 32'h10C, 32'h20C, 32'h000);
    trig_mode = 2'd0;
    pulse_start(32'h000);
    pulse_trig();
    cyc(1);
    pulse_trig();
    cyc(40);
    chk("R9 duplicate trigger dropped", 32'(log_cnt), 1);
    chk("R6 beat mode waits", 32'(busy), 1);
    chk("R11 remain after one beat", 32'(remain), 2);
    pulse_trig();
    cyc(30);
    chk("R6 second beat", 32'(log_cnt), 2);
    abort = 1'b1; cyc(1); abort = 1'b0;
    chk("R11 abort idle", 32'(busy), 0);
    chk("R11 abort remain", 32'(remain), 1);
    cyc(10);
    chk("R11 nothing after abort", 32'(log_cnt), 2);
  endtask

  // block granularity with suspend and resume
  task automatic t_block();
    prep();
    put_desc('h000, ctl_word(1, 2, 1, 1, 3), 16'd2, 32'h108, 32'h208, 32'h010);
    put_desc('h010, ctl_word(1, 2, 1, 1, 0), 16'd1, 32'h114, 32'h214, 32'h000);
    trig_mode = 2'd1;
    pulse_start(32'h000);
    pulse_trig();
    cyc(60);
    chk("R6 block per trigger", 32'(log_cnt), 2);
    chk("R7 done and suspend", {30'd0, flag_done, flag_susp}, 3);
    chk("R7 suspended stays busy", 32'(busy), 1);
    resume = 1'b1; cyc(1); resume = 1'b0;
    cyc(40);
    chk("R6 next block waits trigger", 32'(log_cnt), 2);
    pulse_trig();
    wait_idle(200);
    chk("R2 resumed link run", 32'(log_cnt), 3);
    chk("R3 linked dest", log_addr[2], 32'h210);
    chk("R2 idle at end", 32'(busy), 0);
  endtask

  task automatic t_errors();
    prep();
    put_desc('h000, ctl_word(0, 2, 1, 1, 0), 16'd2, 32'h108, 32'h208, 32'h000);
    trig_mode = 2'd2;
    pulse_start(32'h000);
    pulse_trig();
    wait_idle(200);
    chk("R8 invalid descriptor error", 32'(flag_err), 1);
    chk("R8 invalid no writes", 32'(log_cnt), 0);
    chk("R8 invalid stops", 32'(busy), 0);

    prep();
    put_desc('h000, ctl_word(1, 2, 1, 1, 0), 16'd3, 32'h10C, 32'h20C, 32'h000);
    err_addr = 32'h104;
    pulse_start(32'h000);
    chk("R10 start clears error flag", 32'(flag_err), 0);
    pulse_trig();
    wait_idle(200);
    chk("R8 bus error flag", 32'(flag_err), 1);
    chk("R8 bus error stops after one beat", 32'(log_cnt), 1);

    prep();
    put_desc('h000, ctl_word(1, 2, 1, 1, 0), 16'd1, 32'h104, 32'h204, 32'h010);
    put_desc('h010, ctl_word(1, 2, 1, 1, 0), 16'd0, 32'h104, 32'h204, 32'h000);
    pulse_start(32'h000);
    pulse_trig();
    wait_idle(200);
    chk("R5 linked zero count error", 32'(flag_err), 1);
    chk("R5 linked zero after one beat", 32'(log_cnt), 1);
  endtask

  task automatic t_zero();
    prep();
    put_desc('h000, ctl_word(1, 2, 1, 1, 1), 16'd0, 32'h100, 32'h200, 32'h000);
    trig_mode = 2'd2;
    pulse_start(32'h000);
    pulse_trig();
    wait_idle(100);
    cyc(5);
    chk("R5 zero count status", 32'(stat), 2);
    chk("R5 zero count idle", 32'(busy), 0);
    chk("R5 zero count no error", 32'(flag_err), 0);
    chk("R5 zero count no writes", 32'(log_cnt), 0);
  endtask

  task automatic t_busy();
    prep();
    put_desc('h000, ctl_word(1, 2, 1, 1, 0), 16'd2, 32'h108, 32'h208, 32'h000);
    put_desc('h080, ctl_word(1, 2, 1, 1, 0), 16'd2, 32'h108, 32'h308, 32'h000);
    trig_mode = 2'd0;
    pulse_start(32'h000);
    cyc(20);
    pulse_start(32'h080);
    chk("R10 start while busy status", 32'(stat), 1);
    pulse_trig();
    cyc(30);
    chk("R10 ignored start keeps job", log_addr[0], 32'h200);
    chk("R10 still busy", 32'(busy), 1);
    abort = 1'b1; cyc(1); abort = 1'b0;
    chk("R11 abort second job", 32'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog all R actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; trig = 1'b0; resume = 1'b0; abort = 1'b0;
    start_ptr = '0; trig_mode = 2'd2;
    prep();
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_chain();
    t_bytes();
    t_beat();
    t_block();
    t_errors();
    t_zero();
    t_busy();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule